// File: doc/BRIEF.md
# Hash-based receive queue spreader

This block takes one parsed frame descriptor per cycle and spreads frames over a window of receive queues. From the descriptor it builds a 128-bit flow key out of five header fields: the two IP addresses, the two L4 ports and the IPsec SPI. An extract mask picks which of these fields enter the key. A selected field that the parser marked as absent is replaced by a per-scheme default word, chosen through a 2-bit select code. The key is hashed to 64 bits with a CRC-64 that uses the ECMA polynomial. A shift amount picks a slice of that hash. The slice is masked to a power-of-two window, and a 24-bit queue base is added to give the queue ID.

The scheme configuration is presented as 32-bit words on static inputs. The decoded fields sit at fixed bit positions. A scheme whose enable bit is clear drops the descriptors it receives. The block accepts a descriptor on every cycle and returns the queue ID two cycles later. The output is registered.

Top module: `rxq_spreader`

## Requirements
- R1: After synchronous reset, `out_valid` is low and `in_ready` is high.
- R2: A descriptor accepted while `cfg_mode` bit 31 is set gives `out_valid` high exactly two rising edges later. The descriptor is accepted when `in_valid` and `in_ready` are both high.
- R3: A descriptor accepted while `cfg_mode` bit 31 is clear gives no output.
- R4: The key is {ip_src[31:0], ip_dst[31:0], l4_src[15:0], l4_dst[15:0], spi[31:0]}, most significant bit first. The hash is a CRC-64 over the key: polynomial 0x42F0E1EBA9EA3693, initial value 0, fed MSB first with no reflection. `out_qid` = (base + ((hash >> shift) & mask)) mod 2^24. Here mask = `cfg_hash_cmd`[23:0], shift = `cfg_hash_cmd`[29:24] and base = `cfg_qbase`.
- R5: When a selected IP address field is absent (`has_ip` low), it takes a default from the IP code `cfg_defsel`[19:18]. Code 2 selects `cfg_dv0`, code 3 selects `cfg_dv1`, and any other code selects zero. An absent SPI is zero.
- R6: When a selected L4 port is absent (`has_l4` low), it takes bits [15:0] of a default. The default is chosen by the L4 code `cfg_defsel`[9:8], with the same code meanings as R5.
- R7: A field whose extract bit is clear enters the key as zero, and its input value has no effect. The extract bits are: ip_src bit 20, ip_dst bit 19, l4_src bit 2, l4_dst bit 1, spi bit 9.
- R8: The shift amount selects which 24 bits of the 64-bit hash index the window. Shifts of 0, 24 and 40 each select a different slice.
- R9: With a mask of zero the output equals the base, whatever the field values are.
- R10: With `cfg_hash_cmd` bit 30 set, each source/destination pair enters the key with the smaller value first. The pairs are the IP addresses and the L4 ports. Swapping source and destination then gives the same queue ID.
- R11: base plus offset wraps modulo 2^24.
- R12: Descriptors on consecutive cycles give one output per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Always high; the block never stalls |
| ip_src | input | 32 | Parsed IP source address |
| ip_dst | input | 32 | Parsed IP destination address |
| l4_src | input | 16 | Parsed L4 source port |
| l4_dst | input | 16 | Parsed L4 destination port |
| spi | input | 32 | Parsed IPsec SPI |
| has_ip | input | 1 | IP addresses present |
| has_l4 | input | 1 | L4 ports present |
| has_spi | input | 1 | SPI present |
| cfg_mode | input | 32 | Scheme mode word; bit 31 enables the scheme |
| cfg_extract | input | 32 | Field extract mask |
| cfg_defsel | input | 32 | Default-select codes |
| cfg_dv0 | input | 32 | Scheme default word 0 |
| cfg_dv1 | input | 32 | Scheme default word 1 |
| cfg_hash_cmd | input | 32 | Mask [23:0], shift [29:24], symmetric enable [30] |
| cfg_qbase | input | 24 | Queue base ID |
| out_valid | output | 1 | Queue ID valid |
| out_qid | output | 24 | Selected queue ID |

## Verification
The bench builds the block with the package defaults: a 24-bit queue ID, a 64-bit hash and a 6-bit shift field. It uses a full 24-bit mask for most cases, so every output bit depends on the hash. This lets the reference CRC catch a single wrong key bit. Shifts up to 40 reach the upper half of the hash. A base just below 2^24 drives the wrap, and a zero mask and a disabled scheme cover the degenerate paths.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int WORD_W  = 32;
  localparam int IP_W    = 32;
  localparam int PORT_W  = 16;
  localparam int SPI_W   = 32;
  localparam int HASH_W  = 64;
  localparam int QID_W   = 24;
  localparam int SHIFT_W = 6;
  localparam int KEY_W   = 2 * IP_W + 2 * PORT_W + SPI_W;

  // decoded bit positions inside the configuration words
  localparam int EN_BIT       = 31;
  localparam int X_IPSRC      = 20;
  localparam int X_IPDST      = 19;
  localparam int X_SPI        = 9;
  localparam int X_L4SRC      = 2;
  localparam int X_L4DST      = 1;
  localparam int DS_IP_LSB    = 18;
  localparam int DS_L4_LSB    = 8;
  localparam int HC_SHIFT_LSB = 24;
  localparam int HC_SYM       = 30;

  localparam logic [HASH_W-1:0] CRC_POLY = 64'h42F0_E1EB_A9EA_3693;

  typedef struct packed {
    logic [SHIFT_W-1:0] shift;
    logic [QID_W-1:0]   mask;
    logic [QID_W-1:0]   base;
  } map_cfg_t;

  function automatic logic [WORD_W-1:0] pick_default(
      input logic [1:0] code, input logic [WORD_W-1:0] dv0, input logic [WORD_W-1:0] dv1);
    case (code)
      2'd2:    return dv0;
      2'd3:    return dv1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rxq_key_build.sv
module rxq_key_build
  import rxq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [IP_W-1:0]        ip_src,
  input  logic [IP_W-1:0]        ip_dst,
  input  logic [PORT_W-1:0]      l4_src,
  input  logic [PORT_W-1:0]      l4_dst,
  input  logic [SPI_W-1:0]       spi,
  input  logic                   has_ip,
  input  logic                   has_l4,
  input  logic                   has_spi,
  input  logic [WORD_W-1:0]      cfg_mode,
  input  logic [WORD_W-1:0]      cfg_extract,
  input  logic [WORD_W-1:0]      cfg_defsel,
  input  logic [WORD_W-1:0]      cfg_dv0,
  input  logic [WORD_W-1:0]      cfg_dv1,
  input  logic [WORD_W-1:0]      cfg_hash_cmd,
  input  logic [QID_W-1:0]       cfg_qbase,
  output logic                   s1_valid,
  output logic [KEY_W-1:0]       s1_key,
  output map_cfg_t               s1_cfg
);
  logic [WORD_W-1:0] ip_def, l4_def;
  logic [IP_W-1:0]   ip_a, ip_b, ip_lo, ip_hi;
  logic [PORT_W-1:0] pt_a, pt_b, pt_lo, pt_hi;
  logic [SPI_W-1:0]  spi_v;
  logic              sym;
  logic              unused_cfg;

  assign unused_cfg = ^{cfg_mode, cfg_extract, cfg_defsel, cfg_hash_cmd};

  assign ip_def = pick_default(cfg_defsel[DS_IP_LSB +: 2], cfg_dv0, cfg_dv1);
  assign l4_def = pick_default(cfg_defsel[DS_L4_LSB +: 2], cfg_dv0, cfg_dv1);
  assign sym    = cfg_hash_cmd[HC_SYM];

  // field selection with default substitution
  always_comb begin
    ip_a  = !cfg_extract[X_IPSRC] ? '0 : (has_ip ? ip_src : ip_def[IP_W-1:0]);
    ip_b  = !cfg_extract[X_IPDST] ? '0 : (has_ip ? ip_dst : ip_def[IP_W-1:0]);
    pt_a  = !cfg_extract[X_L4SRC] ? '0 : (has_l4 ? l4_src : l4_def[PORT_W-1:0]);
    pt_b  = !cfg_extract[X_L4DST] ? '0 : (has_l4 ? l4_dst : l4_def[PORT_W-1:0]);
    spi_v = (cfg_extract[X_SPI] && has_spi) ? spi : '0;
  end

  // optional canonical ordering of each source/destination pair
  always_comb begin
    if (sym && (ip_a > ip_b)) begin
      ip_lo = ip_b; ip_hi = ip_a;
    end else begin
      ip_lo = ip_a; ip_hi = ip_b;
    end
    if (sym && (pt_a > pt_b)) begin
      pt_lo = pt_b; pt_hi = pt_a;
    end else begin
      pt_lo = pt_a; pt_hi = pt_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_key   <= '0;
      s1_cfg   <= '0;
    end else begin
      s1_valid     <= in_valid && cfg_mode[EN_BIT];
      s1_key       <= {ip_lo, ip_hi, pt_lo, pt_hi, spi_v};
      s1_cfg.shift <= cfg_hash_cmd[HC_SHIFT_LSB +: SHIFT_W];
      s1_cfg.mask  <= cfg_hash_cmd[QID_W-1:0];
      s1_cfg.base  <= cfg_qbase;
    end
  end

  // R10: with the symmetric option the smaller value of each pair leads the key
  p_sym_order_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sym) |=>
      (s1_key[KEY_W-1 -: IP_W] <= s1_key[KEY_W-IP_W-1 -: IP_W]) &&
      (s1_key[SPI_W+2*PORT_W-1 -: PORT_W] <= s1_key[SPI_W+PORT_W-1 -: PORT_W]));

  // R3: a disabled scheme never loads the pipeline
  p_drop_stage_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_mode[EN_BIT]) |=> !s1_valid);
endmodule

// File: rtl/rxq_crc64.sv
module rxq_crc64
  import rxq_pkg::*;
#(
  parameter int                 DATA_W = KEY_W,
  parameter logic [HASH_W-1:0]  POLY   = CRC_POLY
) (
  input  logic [DATA_W-1:0] data,
  output logic [HASH_W-1:0] crc
);
  // bit-serial division unrolled over the whole key, MSB first, zero seed
  always_comb begin
    logic [HASH_W-1:0] acc;
    logic              fb;
    acc = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb  = acc[HASH_W-1] ^ data[i];
      acc = {acc[HASH_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc = acc;
  end
endmodule

// File: rtl/rxq_qmap.sv
module rxq_qmap
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic [HASH_W-1:0] hash,
  input  map_cfg_t          s1_cfg,
  output logic              out_valid,
  output logic [QID_W-1:0]  out_qid
);
  logic [HASH_W-1:0] shifted;
  logic [QID_W-1:0]  offset;

  assign shifted = hash >> s1_cfg.shift;
  assign offset  = shifted[QID_W-1:0] & s1_cfg.mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_qid   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_qid <= s1_cfg.base + offset;
    end
  end

  // R4: the result stays inside the window above the base
  p_window_r4: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> (((out_qid - $past(s1_cfg.base)) & ~$past(s1_cfg.mask)) == '0));

  // R9: a zero mask returns the base itself
  p_mask_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && (s1_cfg.mask == '0)) |=> (out_qid == $past(s1_cfg.base)));
endmodule

// File: rtl/rxq_spreader.sv
module rxq_spreader
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       ip_src,
  input  logic [31:0]       ip_dst,
  input  logic [15:0]       l4_src,
  input  logic [15:0]       l4_dst,
  input  logic [31:0]       spi,
  input  logic              has_ip,
  input  logic              has_l4,
  input  logic              has_spi,
  input  logic [31:0]       cfg_mode,
  input  logic [31:0]       cfg_extract,
  input  logic [31:0]       cfg_defsel,
  input  logic [31:0]       cfg_dv0,
  input  logic [31:0]       cfg_dv1,
  input  logic [31:0]       cfg_hash_cmd,
  input  logic [23:0]       cfg_qbase,
  output logic              out_valid,
  output logic [23:0]       out_qid
);
  logic              s1_valid;
  logic [KEY_W-1:0]  s1_key;
  map_cfg_t          s1_cfg;
  logic [HASH_W-1:0] hash;

  assign in_ready = 1'b1;

  rxq_key_build u_key (
    .clk, .rst, .in_valid, .ip_src, .ip_dst, .l4_src, .l4_dst, .spi,
    .has_ip, .has_l4, .has_spi, .cfg_mode, .cfg_extract, .cfg_defsel,
    .cfg_dv0, .cfg_dv1, .cfg_hash_cmd, .cfg_qbase,
    .s1_valid, .s1_key, .s1_cfg
  );

  rxq_crc64 #(.DATA_W(KEY_W), .POLY(CRC_POLY)) u_crc (
    .data(s1_key), .crc(hash)
  );

  rxq_qmap u_map (
    .clk, .rst, .s1_valid, .hash, .s1_cfg, .out_valid, .out_qid
  );

  // R2: an enabled descriptor appears two edges later
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && cfg_mode[EN_BIT]) |=> ##1 out_valid);

  // R3: nothing accepted for an enabled scheme means no output two edges later
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && cfg_mode[EN_BIT]) |=> ##1 !out_valid);
endmodule

// File: tb/test_rxq_spreader.sv
module test_rxq_spreader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] ip_src = '0, ip_dst = '0, spi = '0;
  logic [15:0] l4_src = '0, l4_dst = '0;
  logic has_ip = 1'b0, has_l4 = 1'b0, has_spi = 1'b0;
  logic [31:0] cfg_mode = '0, cfg_extract = '0, cfg_defsel = '0;
  logic [31:0] cfg_dv0 = '0, cfg_dv1 = '0, cfg_hash_cmd = '0;
  logic [23:0] cfg_qbase = '0;
  logic out_valid;
  logic [23:0] out_qid;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;

  localparam logic [31:0] ALL_FIELDS = 32'h0018_0206; // bits 20,19,9,2,1
  localparam logic [31:0] MODE_ON    = 32'h8000_0000;
  localparam logic [63:0] POLY       = 64'h42F0_E1EB_A9EA_3693;

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  rxq_spreader i_rxq_spreader (
    .clk, .rst, .in_valid, .in_ready, .ip_src, .ip_dst, .l4_src, .l4_dst, .spi,
    .has_ip, .has_l4, .has_spi, .cfg_mode, .cfg_extract, .cfg_defsel,
    .cfg_dv0, .cfg_dv1, .cfg_hash_cmd, .cfg_qbase, .out_valid, .out_qid
  );

  function automatic logic [31:0] dflt(input logic [1:0] c);
    return (c == 2'd2) ? cfg_dv0 : (c == 2'd3) ? cfg_dv1 : 32'h0;
  endfunction

  // reference model written from the requirements
  function automatic logic [23:0] ref_qid();
    logic [31:0] a, b, s, t;
    logic [15:0] p, q, u;
    logic [127:0] key;
    logic [63:0] h;
    logic [63:0] sh;
    a = cfg_extract[20] ? (has_ip ? ip_src : dflt(cfg_defsel[19:18])) : 32'h0;
    b = cfg_extract[19] ? (has_ip ? ip_dst : dflt(cfg_defsel[19:18])) : 32'h0;
    t = dflt(cfg_defsel[9:8]);
    p = cfg_extract[2] ? (has_l4 ? l4_src : t[15:0]) : 16'h0;
    q = cfg_extract[1] ? (has_l4 ? l4_dst : t[15:0]) : 16'h0;
    s = (cfg_extract[9] && has_spi) ? spi : 32'h0;
    if (cfg_hash_cmd[30]) begin
      if (a > b) begin t = a; a = b; b = t; end
      if (p > q) begin u = p; p = q; q = u; end
    end
    key = {a, b, p, q, s};
    h = '0;
    for (int i = 127; i >= 0; i--) begin
      if (h[63] ^ key[i]) h = (h << 1) ^ POLY;
      else h = h << 1;
    end
    sh = h >> cfg_hash_cmd[29:24];
    return cfg_qbase + (sh[23:0] & cfg_hash_cmd[23:0]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_frame(input logic [31:0] a, input logic [31:0] b,
                           input logic [15:0] p, input logic [15:0] q,
                           input logic [31:0] s, input logic hi, input logic hl,
                           input logic hs);
    ip_src = a; ip_dst = b; l4_src = p; l4_dst = q; spi = s;
    has_ip = hi; has_l4 = hl; has_spi = hs;
  endtask

  task automatic set_cfg(input logic [31:0] mode, input logic [31:0] ext,
                         input logic [31:0] ds, input logic [31:0] hc,
                         input logic [23:0] base);
    cfg_mode = mode; cfg_extract = ext; cfg_defsel = ds;
    cfg_hash_cmd = hc; cfg_qbase = base;
  endtask

  // send one descriptor at a falling edge, return the output two edges later
  task automatic send_one(output logic v, output logic [23:0] qid);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    v = out_valid;
    qid = out_qid;
  endtask

  task automatic send_check(input string req);
    logic v;
    logic [23:0] q, e;
    e = ref_qid();
    send_one(v, q);
    check(req, {31'h0, v}, 32'h1);
    check(req, {8'h0, q}, {8'h0, e});
  endtask

  task automatic t_reset();
    check("R1 out_valid", {31'h0, out_valid}, 32'h0);
    check("R1 in_ready", {31'h0, in_ready}, 32'h1);
  endtask

  task automatic t_basic();
    set_cfg(MODE_ON, ALL_FIELDS, 32'h0008_0300, 32'h0000_00FF, 24'h001000);
    set_frame(32'hC0A8_0001, 32'h0A00_0002, 16'd1234, 16'd80, 32'hDEAD_BEEF, 1, 1, 1);
    send_check("R2 R4 basic");
    set_frame(32'h1111_2222, 32'h3333_4444, 16'hAAAA, 16'h5555, 32'h0, 1, 1, 0);
    cfg_hash_cmd = 32'h00FF_FFFF;
    send_check("R4 full mask");
  endtask

  task automatic t_ip_defaults();
    logic v;
    logic [23:0] q2, q3, q0;
    cfg_dv0 = 32'h0A0A_0A0A; cfg_dv1 = 32'h0B0B_0B0B;
    set_cfg(MODE_ON, ALL_FIELDS, 32'h0008_0000, 32'h00FF_FFFF, 24'h0);
    set_frame(32'h1, 32'h2, 16'd7, 16'd9, 32'h5, 0, 1, 1);
    send_check("R5 ip code2");
    set_frame(32'h1, 32'h2, 16'd7, 16'd9, 32'h5, 0, 1, 1);
    send_one(v, q2);
    cfg_defsel = 32'h000C_0000;
    send_check("R5 ip code3");
    send_one(v, q3);
    cfg_defsel = 32'h0;
    send_check("R5 ip code0");
    send_one(v, q0);
    check("R5 code2 vs code3 differ", {31'h0, q2 != q3}, 32'h1);
    check("R5 code3 vs code0 differ", {31'h0, q3 != q0}, 32'h1);
    // absent SPI with a selected extract bit enters as zero
    set_frame(32'h1, 32'h2, 16'd7, 16'd9, 32'h5, 1, 1, 0);
    send_check("R5 spi absent");
  endtask

  task automatic t_l4_defaults();
    cfg_dv0 = 32'h1234_0A0A; cfg_dv1 = 32'h5678_0B0B;
    set_cfg(MODE_ON, ALL_FIELDS, 32'h0000_0200, 32'h00FF_FFFF, 24'h0);
    set_frame(32'h0101_0101, 32'h0202_0202, 16'hFFFF, 16'hEEEE, 32'h0, 1, 0, 0);
    send_check("R6 l4 code2");
    cfg_defsel = 32'h0000_0300;
    send_check("R6 l4 code3");
  endtask

  task automatic t_unselected();
    logic v;
    logic [23:0] qa, qb;
    set_cfg(MODE_ON, 32'h0018_0000, 32'h0, 32'h00FF_FFFF, 24'h0);
    set_frame(32'hAABB_CCDD, 32'h1122_3344, 16'd1, 16'd2, 32'h3, 1, 1, 1);
    send_check("R7 ip only");
    send_one(v, qa);
    set_frame(32'hAABB_CCDD, 32'h1122_3344, 16'd999, 16'd888, 32'h777, 1, 1, 1);
    send_one(v, qb);
    check("R7 unselected fields ignored", {8'h0, qb}, {8'h0, qa});
  endtask

  task automatic t_shift();
    set_cfg(MODE_ON, ALL_FIELDS, 32'h0, 32'h00FF_FFFF, 24'h0);
    set_frame(32'h0BAD_F00D, 32'hFEED_FACE, 16'd443, 16'd5001, 32'h0000_1000, 1, 1, 1);
    send_check("R8 shift 0");
    cfg_hash_cmd = 32'h18FF_FFFF;
    send_check("R8 shift 24");
    cfg_hash_cmd = 32'h28FF_FFFF;
    send_check("R8 shift 40");
  endtask

  task automatic t_mask_zero();
    set_cfg(MODE_ON, 32'h0, 32'h0, 32'h0, 24'h00ABCD);
    set_frame(32'h5, 32'h6, 16'd7, 16'd8, 32'h9, 1, 1, 1);
    send_check("R9 zero mask");
    cfg_extract = ALL_FIELDS;
    cfg_hash_cmd = 32'h0A00_0000;
    send_check("R9 zero mask with fields");
  endtask

  task automatic t_symmetric();
    logic v;
    logic [23:0] qa, qb;
    set_cfg(MODE_ON, ALL_FIELDS, 32'h0, 32'h40FF_FFFF, 24'h0);
    set_frame(32'hC000_0001, 32'h0A00_0001, 16'd5000, 16'd80, 32'h0, 1, 1, 0);
    send_check("R10 sym forward");
    send_one(v, qa);
    set_frame(32'h0A00_0001, 32'hC000_0001, 16'd80, 16'd5000, 32'h0, 1, 1, 0);
    send_one(v, qb);
    check("R10 sym swap equal", {8'h0, qb}, {8'h0, qa});
  endtask

  task automatic t_wrap();
    set_cfg(MODE_ON, ALL_FIELDS, 32'h0, 32'h0000_00FF, 24'hFFFF_F0);
    set_frame(32'h7, 32'h8, 16'd9, 16'd10, 32'h11, 1, 1, 1);
    send_check("R11 wrap");
  endtask

  task automatic t_drop();
    logic v;
    logic [23:0] q;
    set_cfg(32'h7FFF_FFFF, ALL_FIELDS, 32'h0, 32'h00FF_FFFF, 24'h0);
    set_frame(32'h1, 32'h2, 16'd3, 16'd4, 32'h5, 1, 1, 1);
    send_one(v, q);
    check("R3 drop", {31'h0, v}, 32'h0);
    @(negedge clk);
    check("R3 drop later", {31'h0, out_valid}, 32'h0);
    cfg_mode = MODE_ON;
    send_check("R3 recovers when enabled");
  endtask

  task automatic t_b2b();
    logic [23:0] ea, eb, ec;
    set_cfg(MODE_ON, ALL_FIELDS, 32'h0, 32'h00FF_FFFF, 24'h000100);
    set_frame(32'h100, 32'h200, 16'd1, 16'd2, 32'h3, 1, 1, 1);
    ea = ref_qid();
    in_valid = 1'b1;
    @(negedge clk);
    ip_src = 32'h101;
    eb = ref_qid();
    @(negedge clk);
    check("R12 first valid", {31'h0, out_valid}, 32'h1);
    check("R12 first", {8'h0, out_qid}, {8'h0, ea});
    ip_src = 32'h102;
    ec = ref_qid();
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 second", {8'h0, out_qid}, {8'h0, eb});
    @(negedge clk);
    check("R12 third valid", {31'h0, out_valid}, 32'h1);
    check("R12 third", {8'h0, out_qid}, {8'h0, ec});
    @(negedge clk);
    check("R12 idle", {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ip_defaults();
    t_l4_defaults();
    t_unselected();
    t_shift();
    t_mask_zero();
    t_symmetric();
    t_wrap();
    t_drop();
    t_b2b();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule